// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and a byte-wide asynchronous static RAM with a 17-bit address. The host issues one read or one write at a time over a valid/ready handshake. The controller turns each request into a RAM cycle whose phases last a whole number of clocks. Each phase length is derived from the RAM's minimum timings and a clock-period parameter, and every value is rounded up. There are two timing sets: a fast set for the higher supply and a slower set for the low-voltage supply. A mode input picks the set, and the controller samples it when it accepts a request.

A read asserts both selects and output enable, holds them for the access time, and captures the bus on the last clock. It returns the byte with a single-cycle valid pulse. It then deselects the RAM and waits out the RAM's output-disable time before taking another request.

A write asserts the selects for one setup clock with write enable and output enable both high. It then pulls write enable low for the pulse width. The controller's data driver is enabled only while write enable is low, and output enable stays high throughout, so the RAM and the controller never drive the bus together. Between requests both selects are inactive. The bus is split into an output, an output enable and an input; the pad makes the tristate.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, the block presents an idle state: `ram_cs1_n`=1, `ram_cs2`=0, `ram_oe_n`=1, `ram_we_n`=1, `ram_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: Whenever `req_ready` is high, the RAM is deselected (`ram_cs1_n`=1, `ram_cs2`=0) and both strobes are high.
- R3: A read keeps the RAM selected with `ram_oe_n`=0 and `ram_we_n`=1 for RD clocks, where RD is the larger of ceil(access/T) and ceil(cycle/T). At T=5 ns this gives 14 in fast mode (70 ns) and 20 in low-voltage mode (100 ns). The bus is captured on the last of these clocks. `rsp_valid` is high for exactly one cycle, starting RD clock edges after the accepting edge, with the captured byte on `rsp_rdata`.
- R4: A write spends one clock selected with both strobes high. It then holds `ram_we_n`=0 for WP clocks, where WP is the largest of ceil(pulse/T), ceil(addr-to-end/T), ceil(data setup/T) and ceil(cycle/T)-1. At T=5 ns this is 13 in fast mode and 19 in low-voltage mode. `req_ready` returns 1+WP edges after acceptance.
- R5: `ram_oe_n` is high in every cycle in which `ram_we_n` is low.
- R6: `ram_dq_oe` is high only while the RAM is selected with `ram_we_n` low. `ram_dq_o` holds the request's write data, unchanged, for the whole low pulse.
- R7: While the RAM is selected, `ram_addr` equals the accepted request's address and does not change.
- R8: After a read, the RAM stays deselected for TA = ceil(output-disable/T) clocks before `req_ready` rises. At T=5 ns TA is 6 in fast mode (30 ns) and 7 in low-voltage mode (35 ns), so `req_ready` returns RD+TA edges after acceptance.
- R9: `lv_mode`=1 selects the low-voltage timing set and 0 the fast set. The level is taken on the accepting edge, and later changes do not affect the cycle in progress.
- R10: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is low from the next cycle until the cycle finishes. Writes produce no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lv_mode | input | 1 | 1 = low-voltage timing set, 0 = fast set |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_rdata | output | 8 | Captured read data |
| ram_addr | output | 17 | RAM address |
| ram_cs1_n | output | 1 | Active-low RAM select |
| ram_cs2 | output | 1 | Active-high RAM select |
| ram_oe_n | output | 1 | Active-low RAM output enable |
| ram_we_n | output | 1 | Active-low RAM write enable |
| ram_dq_o | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable for the data driver toward the RAM |
| ram_dq_i | input | 8 | Data from the RAM |

## Verification
Every latency is counted in rising edges from the edge that accepts the request. Read data is due RD edges later, and `req_ready` returns RD+TA edges later for reads and 1+WP edges later for writes. The bench samples on the falling edge after each rising edge and compares the count against values it computes from the nanosecond figures. The RAM model in the bench counts how long output enable has been low and returns the inverted byte until RD clocks have passed, so a capture taken one clock early shows up as wrong data. The model also measures each write-enable pulse and the gap between a read ending and the controller driving the bus again.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    // Minimum timings of one supply mode, in nanoseconds.
    typedef struct packed {
        int unsigned acc_ns;   // address / select to data
        int unsigned oe_ns;    // output enable to data
        int unsigned rc_ns;    // read cycle
        int unsigned wp_ns;    // write strobe low width
        int unsigned aw_ns;    // address and select valid before strobe rise
        int unsigned wc_ns;    // write cycle
        int unsigned dw_ns;    // data valid before strobe rise
        int unsigned hz_ns;    // RAM output release after disable
    } tset_t;

    localparam tset_t FAST_SET = '{acc_ns: 70, oe_ns: 35, rc_ns: 70, wp_ns: 55,
                                   aw_ns: 60, wc_ns: 70, dw_ns: 30, hz_ns: 30};
    localparam tset_t LOWV_SET = '{acc_ns: 100, oe_ns: 50, rc_ns: 100, wp_ns: 70,
                                   aw_ns: 70, wc_ns: 100, dw_ns: 50, hz_ns: 35};

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Round a nanosecond minimum up to whole clocks of the given period.
    function automatic int unsigned ns_to_clk(input int unsigned ns, input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned rd_clks(input tset_t t, input int unsigned p);
        return umax(umax(ns_to_clk(t.acc_ns, p), ns_to_clk(t.oe_ns, p)), umax(ns_to_clk(t.rc_ns, p), 1));
    endfunction

    // The setup clock ahead of the strobe counts toward the cycle time.
    function automatic int unsigned wp_clks(input tset_t t, input int unsigned p);
        int unsigned wc;
        wc = ns_to_clk(t.wc_ns, p);
        wc = (wc > 1) ? wc - 1 : 1;
        return umax(umax(ns_to_clk(t.wp_ns, p), ns_to_clk(t.aw_ns, p)), umax(ns_to_clk(t.dw_ns, p), wc));
    endfunction

    function automatic int unsigned ta_clks(input tset_t t, input int unsigned p);
        return umax(ns_to_clk(t.hz_ns, p), 1);
    endfunction

    function automatic int unsigned max_phase(input int unsigned p);
        return umax(umax(umax(rd_clks(FAST_SET, p), rd_clks(LOWV_SET, p)),
                         umax(wp_clks(FAST_SET, p), wp_clks(LOWV_SET, p))),
                    umax(ta_clks(FAST_SET, p), ta_clks(LOWV_SET, p)));
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE
    } ctl_state_e;

    // Internal active-high view of the RAM control pins.
    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic drv;
    } pin_ctl_t;

endpackage

// File: rtl/sram_timing.sv
`timescale 1ns/1ps
module sram_timing
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_PS = 5000,
    parameter int unsigned CNT_W  = 5
) (
    input  logic             lv_sel,
    output logic [CNT_W-1:0] rd_last,
    output logic [CNT_W-1:0] wp_last,
    output logic [CNT_W-1:0] ta_last
);
    // Phase lengths minus one, as loaded into a down-counter.
    localparam int unsigned RD_F = rd_clks(FAST_SET, CLK_PS);
    localparam int unsigned RD_L = rd_clks(LOWV_SET, CLK_PS);
    localparam int unsigned WP_F = wp_clks(FAST_SET, CLK_PS);
    localparam int unsigned WP_L = wp_clks(LOWV_SET, CLK_PS);
    localparam int unsigned TA_F = ta_clks(FAST_SET, CLK_PS);
    localparam int unsigned TA_L = ta_clks(LOWV_SET, CLK_PS);

    localparam logic [CNT_W-1:0] RD_F_C = CNT_W'(RD_F - 1);
    localparam logic [CNT_W-1:0] RD_L_C = CNT_W'(RD_L - 1);
    localparam logic [CNT_W-1:0] WP_F_C = CNT_W'(WP_F - 1);
    localparam logic [CNT_W-1:0] WP_L_C = CNT_W'(WP_L - 1);
    localparam logic [CNT_W-1:0] TA_F_C = CNT_W'(TA_F - 1);
    localparam logic [CNT_W-1:0] TA_L_C = CNT_W'(TA_L - 1);

    always_comb begin
        rd_last = lv_sel ? RD_L_C : RD_F_C;
        wp_last = lv_sel ? WP_L_C : WP_F_C;
        ta_last = lv_sel ? TA_L_C : TA_F_C;
    end
endmodule

// File: rtl/sram_cycle_fsm.sv
`timescale 1ns/1ps
module sram_cycle_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             lv_mode,
    input  logic [CNT_W-1:0] rd_last,
    input  logic [CNT_W-1:0] wp_last,
    input  logic [CNT_W-1:0] ta_last,
    output logic             cur_lv,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output pin_ctl_t         pins
);
    ctl_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             mode_q;
    logic             cnt_done;

    assign cnt_done  = (cnt == '0);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    // Live mode on the accepting cycle, latched mode for the rest of the cycle.
    assign cur_lv    = req_ready ? lv_mode : mode_q;
    assign capture   = (state == ST_READ) && cnt_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        mode_q <= lv_mode;
                        if (req_write) begin
                            state <= ST_WSETUP;
                        end else begin
                            state <= ST_READ;
                            cnt   <= rd_last;
                        end
                    end
                end
                ST_READ: begin
                    if (cnt_done) begin
                        state <= ST_TURN;
                        cnt   <= ta_last;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TURN: begin
                    if (cnt_done) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                ST_WSETUP: begin
                    state <= ST_WPULSE;
                    cnt   <= wp_last;
                end
                ST_WPULSE: begin
                    if (cnt_done) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        pins.sel = (state == ST_READ) || (state == ST_WSETUP) || (state == ST_WPULSE);
        pins.oe  = (state == ST_READ);
        pins.we  = (state == ST_WPULSE);
        pins.drv = (state == ST_WPULSE);
    end

    AST_WE_KEEPS_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        pins.we |-> !pins.oe);                                   // R5
    AST_DRIVE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        pins.drv |-> (pins.we && pins.sel));                     // R6
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(pins.sel || pins.oe || pins.we));        // R2
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);                                  // R10
endmodule

// File: rtl/sram_port_regs.sv
`timescale 1ns/1ps
module sram_port_regs #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic              busy,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ram_dq_i,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_addr  <= '0;
            ram_dq_o  <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (accept) begin
                ram_addr <= req_addr;
                ram_dq_o <= req_wdata;
            end
            if (capture) begin
                rsp_rdata <= ram_dq_i;
            end
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(ram_addr) && $stable(ram_dq_o))); // R7
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);                                         // R3
endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CLK_PS = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lv_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs1_n,
    output logic              ram_cs2,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_i
);
    localparam int unsigned CNT_W = $clog2(max_phase(CLK_PS) + 1);

    logic             cur_lv;
    logic             accept;
    logic             capture;
    logic [CNT_W-1:0] rd_last;
    logic [CNT_W-1:0] wp_last;
    logic [CNT_W-1:0] ta_last;
    pin_ctl_t         pins;

    sram_timing #(.CLK_PS(CLK_PS), .CNT_W(CNT_W)) u_timing (
        .lv_sel  (cur_lv),
        .rd_last (rd_last),
        .wp_last (wp_last),
        .ta_last (ta_last)
    );

    sram_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .lv_mode   (lv_mode),
        .rd_last   (rd_last),
        .wp_last   (wp_last),
        .ta_last   (ta_last),
        .cur_lv    (cur_lv),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .pins      (pins)
    );

    sram_port_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .busy      (!req_ready),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ram_dq_i  (ram_dq_i),
        .ram_addr  (ram_addr),
        .ram_dq_o  (ram_dq_o),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign ram_cs1_n = ~pins.sel;
    assign ram_cs2   = pins.sel;
    assign ram_oe_n  = ~pins.oe;
    assign ram_we_n  = ~pins.we;
    assign ram_dq_oe = pins.drv;

    AST_SELECTS_AGREE: assert property (@(posedge clk) disable iff (rst)
        ram_cs1_n == !ram_cs2);                                   // R2
    AST_NO_RSP_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> !rsp_valid);                                // R10
endmodule

// File: tb/sram_cycle_ctrl_test.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_test;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int PER_NS = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lv_mode = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_cs1_n, ram_cs2, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [DW-1:0] ram_dq_o;
    logic [DW-1:0] dq_in = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sram_cycle_ctrl uut (
        .clk(clk), .rst(rst), .lv_mode(lv_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs1_n(ram_cs1_n), .ram_cs2(ram_cs2),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
        .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected phase lengths from the nanosecond minimums at a 5 ns clock.
    function automatic int cdiv(input int ns);
        return (ns + PER_NS - 1) / PER_NS;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic int exp_rd(input bit lv);
        return lv ? imax(cdiv(100), cdiv(100)) : imax(cdiv(70), cdiv(70));
    endfunction
    function automatic int exp_wp(input bit lv);
        return lv ? imax(imax(cdiv(70), cdiv(70)), imax(cdiv(50), cdiv(100) - 1))
                  : imax(imax(cdiv(55), cdiv(60)), imax(cdiv(30), cdiv(70) - 1));
    endfunction
    function automatic int exp_ta(input bit lv);
        return lv ? cdiv(35) : cdiv(30);
    endfunction

    // RAM model state
    logic [DW-1:0] mem [256];
    logic [DW-1:0] sb  [256];
    logic [AW-1:0] cur_addr = '0;
    bit            cur_lv = 1'b0;
    int            acc_run = 0;
    int            we_run = 0;
    int            since_rd = 1000;
    logic [DW-1:0] wd_seen = '0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
            sb[i]  = 8'h00;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit sel = !ram_cs1_n && ram_cs2;
            if (req_ready)
                chk(ram_cs1_n && !ram_cs2 && ram_oe_n && ram_we_n, "R2 idle deselect",
                    {ram_cs1_n, ram_cs2, ram_oe_n, ram_we_n}, 4'b1011);
            if (!ram_we_n)
                chk(ram_oe_n, "R5 oe high during write", ram_oe_n, 1);
            if (ram_dq_oe)
                chk(sel && !ram_we_n, "R6 drive only under strobe", {sel, ram_we_n}, 2'b10);
            if (sel)
                chk(ram_addr == cur_addr, "R7 address", ram_addr, cur_addr);
            // write strobe tracking
            if (sel && !ram_we_n) begin
                if (we_run == 0) begin
                    wd_seen = ram_dq_o;
                    chk(since_rd >= exp_ta(cur_lv) + 1, "R8 turnaround before drive",
                        since_rd, exp_ta(cur_lv) + 1);
                end else begin
                    chk(ram_dq_o == wd_seen, "R6 data stable", ram_dq_o, wd_seen);
                end
                chk(ram_dq_oe, "R6 driver on", ram_dq_oe, 1);
                we_run++;
            end else if (we_run != 0) begin
                mem[cur_addr[7:0]] = wd_seen;
                chk(we_run == exp_wp(cur_lv), "R4 strobe width", we_run, exp_wp(cur_lv));
                we_run = 0;
            end
            // read access tracking
            if (sel && !ram_oe_n && ram_we_n) begin
                acc_run++;
                since_rd = 0;
                dq_in = (acc_run >= exp_rd(cur_lv)) ? mem[cur_addr[7:0]] : ~mem[cur_addr[7:0]];
            end else begin
                acc_run = 0;
                if (since_rd < 1000) since_rd++;
                dq_in = 8'h3C;
            end
        end
    end

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit lv);
        int lat;
        bit seen;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; lv_mode = lv;
        while (!req_ready) @(negedge clk);
        cur_addr = a;
        cur_lv = lv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lv_mode = ~lv;               // R9: must not affect the cycle in flight
        req_addr = ~a;
        req_wdata = ~d;
        chk(!req_ready, "R10 busy after accept", req_ready, 0);
        lat = 0;
        seen = 1'b0;
        if (wr) sb[a[7:0]] = d;
        while (!req_ready && lat < 1000) begin
            if (rsp_valid) begin
                if (wr) begin
                    chk(1'b0, "R10 no response on write", 1, 0);
                end else begin
                    chk(!seen, "R3 single pulse", 1, 0);
                    chk(lat == exp_rd(lv), "R3 R9 read latency", lat, exp_rd(lv));
                    chk(rsp_rdata == sb[a[7:0]], "R3 read data", rsp_rdata, sb[a[7:0]]);
                    seen = 1'b1;
                end
            end
            @(negedge clk);
            lat++;
        end
        if (wr) chk(lat == 1 + exp_wp(lv), "R4 R9 write done latency", lat, 1 + exp_wp(lv));
        else begin
            chk(seen, "R3 response seen", seen, 1);
            chk(lat == exp_rd(lv) + exp_ta(lv), "R8 R9 read done latency", lat, exp_rd(lv) + exp_ta(lv));
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int i);
        return (i == 15) ? 17'h1FFFF : AW'(i * 8209);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(ram_cs1_n && !ram_cs2 && ram_oe_n && ram_we_n && !ram_dq_oe && req_ready && !rsp_valid,
            "R1 reset state", {ram_cs1_n, ram_cs2, ram_oe_n, ram_we_n, ram_dq_oe, req_ready, rsp_valid},
            7'b1011010);
        rst = 1'b0;
        @(negedge clk);
        chk(ram_cs1_n && !ram_cs2 && !ram_dq_oe && req_ready && !rsp_valid, "R1 after reset",
            {ram_cs1_n, ram_cs2, ram_dq_oe, req_ready, rsp_valid}, 5'b10010);
        for (int lv = 0; lv < 2; lv++) begin
            for (int i = 0; i < 16; i++)
                do_op(1'b1, addr_of(i), DW'(i * 37 + lv * 90) ^ ((i % 2) ? 8'hFF : 8'h55), lv[0]);
            for (int i = 0; i < 16; i++)
                do_op(1'b0, addr_of(i), 8'h00, lv[0]);
            // alternate write and read so each write follows a read turnaround
            for (int i = 0; i < 16; i++) begin
                do_op(1'b1, addr_of(i), (i % 2) ? 8'hAA : 8'h00, lv[0]);
                do_op(1'b0, addr_of(i), 8'h00, lv[0]);
                do_op(1'b0, addr_of(15 - i), 8'h00, !lv[0]);
            end
        end
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PER_NS * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule